// File: doc/BRIEF.md
# Stereo Lip-Sync Delay Line

This block delays a stereo audio stream by a run-time programmable number of sample frames. The aim is to line up sound with a slower video path. It sits between a serial audio receiver and a serial audio transmitter.

On each frame strobe it takes one 24-bit left word and one 24-bit right word. It keeps the upper 16 bits of each word in a shared on-chip circular buffer. It then returns the pair that was written the selected number of frames earlier. One delay setting applies to both channels. A mode input chooses one of three outputs:

- silence;
- the current frame at full precision;
- the delayed frame.

The default buffer holds 2048 frames per channel. That covers 46 ms at 44.1 kHz and 42 ms at 48 kHz, and a longer span at 32 kHz.

Control is a two-state emit machine:

- **ST_IDLE** moves to **ST_EMIT** when a strobe arrives.
- **ST_EMIT** presents the result of the frame accepted one clock earlier.
- **ST_EMIT** stays in ST_EMIT when a further strobe arrives in that same cycle (back-to-back frames). Otherwise it returns to ST_IDLE.

The mode and the delay are sampled on the strobe, so each frame is processed with the settings that were present at its own strobe. After reset, the delayed output stays silent until enough frames have been stored to cover the selected delay.

Top module: `lipsync_delay`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is low and both outputs are zero until the first frame is emitted.
- R2: A strobe sampled on clock edge k produces exactly one out_valid pulse, visible after edge k+1. out_valid is never high without such a strobe.
- R3: In delayed mode (mode = 2'b10) with effective delay D, the output pair of frame n is the input pair of frame n-D. Both channels use the same D.
- R4: In delayed mode the output carries input bits [23:8] in bits [23:8], and bits [7:0] are zero.
- R5: In through mode (mode = 2'b01) the output is the full 24-bit input pair of the same frame.
- R6: In mute mode (mode = 2'b00), and for the unused code 2'b11, both outputs are zero, and out_valid still pulses.
- R7: In delayed mode with a delay of 0, the output is the current frame at stored precision (bits [7:0] zero).
- R8: A requested delay above DEPTH-1 (2047 by default) acts as DEPTH-1.
- R9: In delayed mode the output is zero while fewer than D frames have been accepted since reset.
- R10: A strobe in the same cycle as an emission is accepted, and neither frame is lost or corrupted.
- R11: Outputs hold their value in every cycle without an emission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame strobe, one cycle per frame |
| in_left | input | 24 | Left input sample |
| in_right | input | 24 | Right input sample |
| delay_frames | input | 12 | Requested delay in frames |
| mode | input | 2 | 00 mute, 01 through, 10 delayed, 11 mute |
| out_valid | output | 1 | Output pair is updated this cycle |
| out_left | output | 24 | Left output sample |
| out_right | output | 24 | Right output sample |

## Verification
Two things can fall in the same cycle: the emission of one frame and the acceptance of the next.

When frames arrive back to back, ST_EMIT must load the previous frame's result. In that same cycle it must capture the new mode, the new samples and the new buffer read.

The bench provokes this with strobes held high on consecutive clocks, with small delays of 1 and 5. A delay of 1 makes the read hit the word written one clock before. A behavioural queue model predicts every cycle's out_valid and output words, and any slip or merge shows up as a mismatch on those clocks.

// File: rtl/lipsync_pkg.sv
package lipsync_pkg;

    typedef enum logic [1:0] {
        MODE_MUTE  = 2'b00,
        MODE_THRU  = 2'b01,
        MODE_DELAY = 2'b10,
        MODE_RSVD  = 2'b11
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_st_e;

endpackage

// File: rtl/lipsync_ram.sv
module lipsync_ram #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2048,
    parameter int AW     = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     wa,
    input  logic [WORD_W-1:0] wd,
    input  logic              re,
    input  logic [AW-1:0]     ra,
    output logic [WORD_W-1:0] rq
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Read-first single-clock array; a same-address collision returns old data
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
        if (re) begin
            rq <= mem[ra];
        end
    end

endmodule

// File: rtl/lipsync_addr.sv
module lipsync_addr #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11,
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic [DLY_W-1:0] req_delay,
    output logic [AW-1:0]    wr_addr,
    output logic [AW-1:0]    rd_addr,
    output logic [DLY_W-1:0] dly_eff,
    output logic             have_hist,
    output logic             zero_dly
);

    localparam int MAX_DELAY = DEPTH - 1;
    localparam int CW        = (DLY_W > AW + 1) ? DLY_W : AW + 1;

    logic [AW-1:0] wptr_q;
    logic [AW:0]   fill_q;
    logic [CW-1:0] wp_ext, d_ext, fill_ext, rd_ext;

    // Delay clamp: the buffer can look back at most DEPTH-1 frames
    always_comb begin
        if (req_delay > DLY_W'(MAX_DELAY)) begin
            dly_eff = DLY_W'(MAX_DELAY);
        end else begin
            dly_eff = req_delay;
        end
    end

    // Circular read address: write pointer minus delay, wrapped into the array
    always_comb begin
        wp_ext   = CW'(wptr_q);
        d_ext    = CW'(dly_eff);
        fill_ext = CW'(fill_q);
        if (wp_ext >= d_ext) begin
            rd_ext = wp_ext - d_ext;
        end else begin
            rd_ext = wp_ext + CW'(DEPTH) - d_ext;
        end
        rd_addr   = rd_ext[AW-1:0];
        wr_addr   = wptr_q;
        have_hist = (d_ext <= fill_ext);
        zero_dly  = (dly_eff == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            fill_q <= '0;
        end else if (advance) begin
            if (wptr_q == AW'(DEPTH - 1)) begin
                wptr_q <= '0;
            end else begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (fill_q != (AW+1)'(DEPTH)) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_q <= (AW+1)'(DEPTH)); // R9
    AST_COLLIDE_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == wr_addr) |-> zero_dly); // R7

endmodule

// File: rtl/lipsync_ctrl.sv
module lipsync_ctrl
    import lipsync_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int KEEP_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_left,
    input  logic [DATA_W-1:0]   in_right,
    input  logic [1:0]          mode,
    input  logic                have_hist,
    input  logic                zero_dly,
    input  logic [2*KEEP_W-1:0] ram_q,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_left,
    output logic [DATA_W-1:0]   out_right
);

    localparam int PAD = DATA_W - KEEP_W;

    emit_st_e            st_q, st_nx;
    mode_e               mode_q;
    logic [DATA_W-1:0]   cap_l_q, cap_r_q;
    logic                hist_ok_q, zero_q;
    logic [DATA_W-1:0]   sel_l, sel_r;

    function automatic logic [DATA_W-1:0] widen(input logic [KEEP_W-1:0] k);
        return {k, {PAD{1'b0}}};
    endfunction

    // Per-frame capture of settings and samples on the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_MUTE;
            cap_l_q   <= '0;
            cap_r_q   <= '0;
            hist_ok_q <= 1'b0;
            zero_q    <= 1'b0;
        end else if (in_valid) begin
            mode_q    <= mode_e'(mode);
            cap_l_q   <= in_left;
            cap_r_q   <= in_right;
            hist_ok_q <= have_hist;
            zero_q    <= zero_dly;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: if (in_valid)  st_nx = ST_EMIT;
            ST_EMIT: if (!in_valid) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // Output selection for the frame being emitted
    always_comb begin
        sel_l = '0;
        sel_r = '0;
        unique case (mode_q)
            MODE_THRU: begin
                sel_l = cap_l_q;
                sel_r = cap_r_q;
            end
            MODE_DELAY: begin
                if (zero_q) begin
                    sel_l = widen(cap_l_q[DATA_W-1 -: KEEP_W]);
                    sel_r = widen(cap_r_q[DATA_W-1 -: KEEP_W]);
                end else if (hist_ok_q) begin
                    sel_l = widen(ram_q[2*KEEP_W-1 -: KEEP_W]);
                    sel_r = widen(ram_q[KEEP_W-1:0]);
                end
            end
            MODE_MUTE, MODE_RSVD: begin
                sel_l = '0;
                sel_r = '0;
            end
            default: begin
                sel_l = '0;
                sel_r = '0;
            end
        endcase
    end

    // Output register process
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (st_q)
                ST_EMIT: begin
                    out_valid <= 1'b1;
                    out_left  <= sel_l;
                    out_right <= sel_r;
                end
                ST_IDLE: ;
                default: ;
            endcase
        end
    end

    AST_STROBE_EMITS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid); // R2
    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EMIT && (mode_q == MODE_MUTE || mode_q == MODE_RSVD))
        |=> (out_left == '0 && out_right == '0)); // R6
    AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EMIT && mode_q == MODE_DELAY)
        |=> (out_left[PAD-1:0] == '0 && out_right[PAD-1:0] == '0)); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |=> ($stable(out_left) && $stable(out_right))); // R11

endmodule

// File: rtl/lipsync_delay.sv
module lipsync_delay #(
    parameter int DATA_W = 24,
    parameter int KEEP_W = 16,
    parameter int DEPTH  = 2048,
    parameter int DLY_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic [DLY_W-1:0]  delay_frames,
    input  logic [1:0]        mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);

    localparam int AW     = $clog2(DEPTH);
    localparam int WORD_W = 2 * KEEP_W;

    logic [AW-1:0]     wr_addr, rd_addr;
    logic [DLY_W-1:0]  dly_eff;
    logic              have_hist, zero_dly;
    logic [WORD_W-1:0] wr_word, ram_q;

    assign wr_word = {in_left[DATA_W-1 -: KEEP_W], in_right[DATA_W-1 -: KEEP_W]};

    lipsync_addr #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DLY_W (DLY_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .advance   (in_valid),
        .req_delay (delay_frames),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .dly_eff   (dly_eff),
        .have_hist (have_hist),
        .zero_dly  (zero_dly)
    );

    lipsync_ram #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .AW     (AW)
    ) u_ram (
        .clk (clk),
        .we  (in_valid),
        .wa  (wr_addr),
        .wd  (wr_word),
        .re  (in_valid),
        .ra  (rd_addr),
        .rq  (ram_q)
    );

    lipsync_ctrl #(
        .DATA_W (DATA_W),
        .KEEP_W (KEEP_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .mode      (mode),
        .have_hist (have_hist),
        .zero_dly  (zero_dly),
        .ram_q     (ram_q),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

    AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (rst)
        dly_eff <= DLY_W'(DEPTH - 1)); // R8

endmodule

// File: tb/lipsync_delay_bench.sv
module lipsync_delay_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;
    localparam int MAXD       = DEPTH - 1;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic [11:0] delay_frames = '0;
    logic [1:0]  mode = 2'b00;
    logic        out_valid;
    logic [23:0] out_left, out_right;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    string tag = "R1";

    lipsync_delay u_lipsync_delay (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_left      (in_left),
        .in_right     (in_right),
        .delay_frames (delay_frames),
        .mode         (mode),
        .out_valid    (out_valid),
        .out_left     (out_left),
        .out_right    (out_right)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [23:0] hl[$], hr[$];
    logic        pend = 1'b0, ev = 1'b0;
    logic [23:0] pl = '0, pr = '0, el = '0, er = '0;

    function automatic logic [23:0] trunc(input logic [23:0] x);
        return {x[23:8], 8'h00};
    endfunction

    always @(posedge clk) begin
        int d, n;
        logic [23:0] tl, tr;
        if (rst) begin
            pend <= 1'b0; ev <= 1'b0; el <= '0; er <= '0;
            hl.delete(); hr.delete();
        end else begin
            ev <= pend;
            if (pend) begin el <= pl; er <= pr; end
            pend <= in_valid;
            if (in_valid) begin
                d = (int'(delay_frames) > MAXD) ? MAXD : int'(delay_frames);
                n = hl.size();
                tl = '0; tr = '0;
                if (mode == 2'b01) begin
                    tl = in_left; tr = in_right;
                end else if (mode == 2'b10) begin
                    if (d == 0) begin
                        tl = trunc(in_left); tr = trunc(in_right);
                    end else if (d <= n) begin
                        tl = trunc(hl[n-d]); tr = trunc(hr[n-d]);
                    end
                end
                pl <= tl; pr <= tr;
                hl.push_back(in_left); hr.push_back(in_right);
                if (hl.size() > DEPTH) begin
                    void'(hl.pop_front()); void'(hr.pop_front());
                end
            end
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (out_valid !== ev) begin
                failures++;
                $display("FAIL %s/R2 out_valid act=%0b exp=%0b t=%0t", tag, out_valid, ev, $time);
            end
            checks++;
            if (out_left !== el || out_right !== er) begin
                failures++;
                $display("FAIL %s/R11 out act=%h/%h exp=%h/%h t=%0t",
                         tag, out_left, out_right, el, er, $time);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp=<%0d cycles", cyc, WATCHDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic send(input int gap);
        in_valid = 1'b1;
        in_left  = 24'($urandom);
        in_right = 24'($urandom);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic run(input int frames, input int gap);
        for (int i = 0; i < frames; i++) send(gap);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_left !== '0 || out_right !== '0) begin
            failures++;
            $display("FAIL R1 in reset act=%0b/%h/%h exp=0/0/0", out_valid, out_left, out_right);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_left !== '0 || out_right !== '0) begin
            failures++;
            $display("FAIL R1 after reset act=%0b/%h/%h exp=0/0/0", out_valid, out_left, out_right);
        end

        tag = "R3 R4 R9"; mode = 2'b10; delay_frames = 12'd3;
        run(40, 3);
        tag = "R5"; mode = 2'b01;
        run(20, 2);
        tag = "R6 mute"; mode = 2'b00;
        run(10, 2);
        tag = "R6 code11"; mode = 2'b11;
        run(10, 2);
        tag = "R7"; mode = 2'b10; delay_frames = 12'd0;
        run(20, 2);
        tag = "R3 change"; delay_frames = 12'd10;
        run(30, 4);
        tag = "R10 d5"; delay_frames = 12'd5;
        run(30, 0);
        tag = "R10 d1"; delay_frames = 12'd1;
        run(20, 0);
        tag = "R10 mixed"; mode = 2'b01;
        run(5, 0);
        mode = 2'b10;
        run(5, 0);
        tag = "R8 R9 clamp"; delay_frames = 12'd4000;
        run(2100, 1);
        tag = "R8 max"; delay_frames = 12'd2047;
        run(20, 1);
        tag = "R11 idle";
        repeat (20) @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule